// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a memory and decides, for each request, whether a store may reach the array. It keeps one reservation slot per hardware context. A load-locked request fills the slot of the issuing context with the request's address, rounded down to a 16-byte block. Every store is checked against the slots. A conditional store is allowed to write only if its own context still holds a reservation on the same block. Any store that does write clears every reservation, from any context, on that block.

The request port takes one request per clock: a valid strobe, a byte address, a context number and three flags (load-locked, store, conditional). Two registered results appear on the next cycle: a write-enable for the memory and a success bit for conditional stores. Reservation changes made by one request are seen by the request that follows it. The memory array and the read data path lie outside the block.

Top module: `llsc_monitor`

## Requirements
- R1: Addresses are compared on 16-byte blocks. Address bits [3:0] are ignored when a reservation is stored or matched.
- R2: A valid request with the load-locked flag set and the store flag clear records a reservation for its context at its block. For that request `wr_en` and `sc_ok` are 0.
- R3: Each context holds at most one reservation. A new load-locked from the same context replaces the earlier one.
- R4: A valid request with the store flag set and the conditional flag clear (ordinary store) always gives `wr_en`=1 and `sc_ok`=0, whether or not any reservations are held.
- R5: A store that writes (`wr_en`=1) clears the reservation of every context whose block matches the store's block.
- R6: When no reservations are held, a conditional store (store and conditional flags both set) gives `wr_en`=0 and `sc_ok`=0.
- R7: A conditional store succeeds only if the requesting context's own reservation matches its block. It then gives `wr_en`=1 and `sc_ok`=1, and it clears every matching reservation, its own included.
- R8: A failed conditional store gives `wr_en`=0 and `sc_ok`=0 and leaves all reservations unchanged.
- R9: Results are registered and due exactly one clock after the request. A cycle with `req_valid`=0 gives `wr_en`=0 and `sc_ok`=0 on the next cycle. The next request sees the reservation updates made by the previous one.
- R10: Reset (asynchronous assertion, synchronous release) invalidates all reservations and clears both outputs.
- R11: When both the load-locked and store flags are set, the request is treated as a store and makes no reservation. The conditional flag on a non-store request has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_ctx | input | CTX_W | Issuing context number |
| req_ll | input | 1 | Load-locked flag |
| req_st | input | 1 | Store flag |
| req_cond | input | 1 | Conditional flag (applies to stores) |
| wr_en | output | 1 | The previous cycle's store may write memory |
| sc_ok | output | 1 | The previous cycle's conditional store succeeded |

## Verification
Both `wr_en` and `sc_ok` are due one clock edge after the request is presented. The bench drives each request on a falling edge and reads the results on the following falling edge, after the single rising edge that registers them. Requests are issued back to back, so a check on one result also shows whether the previous request's reservation update is visible to the next one. Reset release passes through a two-stage synchronizer, so the bench waits several cycles after releasing reset before it sends the first request.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LL   = 2'd1,
    OP_ST   = 2'd2,
    OP_SC   = 2'd3
  } llsc_op_e;

  // A store flag takes precedence over load-locked; conditional only qualifies stores.
  function automatic llsc_op_e decode_op(input logic vld, input logic ll,
                                         input logic st, input logic cond);
    if (!vld)        return OP_NONE;
    if (st && cond)  return OP_SC;
    if (st)          return OP_ST;
    if (ll)          return OP_LL;
    return OP_NONE;
  endfunction

endpackage

// File: rtl/llsc_slot.sv
module llsc_slot #(
  parameter int TAG_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] set_tag,
  output logic             vld,
  output logic [TAG_W-1:0] tag
);

  logic             vld_nxt;
  logic [TAG_W-1:0] tag_nxt;
  logic             tag_ce;

  always_comb begin
    vld_nxt = vld;
    if (clr_en) vld_nxt = 1'b0;
    if (set_en) vld_nxt = 1'b1;
    tag_ce  = set_en;
    tag_nxt = set_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= 1'b0;
    else        vld <= vld_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tag <= '0;
    else if (tag_ce) tag <= tag_nxt;
  end

  // R3: a fill leaves the slot valid and holding the new block
  p_fill_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (vld && tag == $past(set_tag)));

  // R5: a clear without a fill drops the reservation
  p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> !vld);

endmodule

// File: rtl/llsc_verdict.sv
module llsc_verdict
  import llsc_pkg::*;
#(
  parameter int NCTX  = 4,
  parameter int CTX_W = 2,
  parameter int TAG_W = 28
) (
  input  logic                       req_valid,
  input  logic                       req_ll,
  input  logic                       req_st,
  input  logic                       req_cond,
  input  logic [CTX_W-1:0]           req_ctx,
  input  logic [TAG_W-1:0]           req_tag,
  input  logic [NCTX-1:0]            slot_vld,
  input  logic [NCTX-1:0][TAG_W-1:0] slot_tag,
  output logic [NCTX-1:0]            set_vec,
  output logic [NCTX-1:0]            clr_vec,
  output logic                       wr_d,
  output logic                       ok_d
);

  llsc_op_e        op;
  logic [NCTX-1:0] hit;
  logic [NCTX-1:0] mine;
  logic            own_hit;

  assign op = decode_op(req_valid, req_ll, req_st, req_cond);

  for (genvar g = 0; g < NCTX; g++) begin : g_cmp
    assign hit[g]  = slot_vld[g] && (slot_tag[g] == req_tag);
    assign mine[g] = (req_ctx == CTX_W'(g));
  end

  always_comb begin
    own_hit = |(hit & mine);
    wr_d    = 1'b0;
    ok_d    = 1'b0;
    set_vec = '0;
    unique case (op)
      OP_LL:   set_vec = mine;
      OP_ST:   wr_d    = 1'b1;
      OP_SC: begin
        wr_d = own_hit;
        ok_d = own_hit;
      end
      default: ;
    endcase
    clr_vec = wr_d ? hit : '0;
  end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NCTX      = 4,
  parameter int GRAN_BITS = 4,
  parameter int CTX_W     = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic              req_ll,
  input  logic              req_st,
  input  logic              req_cond,
  output logic              wr_en,
  output logic              sc_ok
);

  localparam int TAG_W = ADDR_W - GRAN_BITS;

  logic [1:0]                 rst_pipe;
  logic                       rst_s_n;
  logic [TAG_W-1:0]           req_tag;
  logic [NCTX-1:0]            slot_vld;
  logic [NCTX-1:0][TAG_W-1:0] slot_tag;
  logic [NCTX-1:0]            set_vec;
  logic [NCTX-1:0]            clr_vec;
  logic                       wr_d;
  logic                       ok_d;

  // Reset: asynchronous assertion, release through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  // R1: block granularity, low bits dropped
  assign req_tag = req_addr[ADDR_W-1:GRAN_BITS];

  for (genvar g = 0; g < NCTX; g++) begin : g_slot
    llsc_slot #(.TAG_W(TAG_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .set_en  (set_vec[g]),
      .clr_en  (clr_vec[g]),
      .set_tag (req_tag),
      .vld     (slot_vld[g]),
      .tag     (slot_tag[g])
    );
  end

  llsc_verdict #(.NCTX(NCTX), .CTX_W(CTX_W), .TAG_W(TAG_W)) u_verdict (
    .req_valid (req_valid),
    .req_ll    (req_ll),
    .req_st    (req_st),
    .req_cond  (req_cond),
    .req_ctx   (req_ctx),
    .req_tag   (req_tag),
    .slot_vld  (slot_vld),
    .slot_tag  (slot_tag),
    .set_vec   (set_vec),
    .clr_vec   (clr_vec),
    .wr_d      (wr_d),
    .ok_d      (ok_d)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      wr_en <= 1'b0;
      sc_ok <= 1'b0;
    end else begin
      wr_en <= wr_d;
      sc_ok <= ok_d;
    end
  end

  // R4: an ordinary store always writes and never reports success
  p_plain_store_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid && req_st && !req_cond) |=> (wr_en && !sc_ok));

  // R7: success is only reported together with a write
  p_ok_with_write_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    sc_ok |-> wr_en);

  // R9: an idle cycle produces quiet outputs next cycle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !req_valid |=> (!wr_en && !sc_ok));

  // R2: non-store requests never write
  p_load_no_write_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid && !req_st) |=> !wr_en);

  // R8: a refused conditional store leaves every slot as it was
  p_fail_keeps_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid && req_st && req_cond && !wr_d) |=> $stable(slot_vld));

  // R3: one load-locked fills at most one slot
  p_single_fill_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(set_vec));

endmodule

// File: tb/test_llsc_monitor.sv
`timescale 1ns/1ps
module test_llsc_monitor;

  localparam int AW   = 32;
  localparam int NCTX = 4;
  localparam int CW   = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ll, req_st, req_cond;
  logic [AW-1:0] req_addr;
  logic [CW-1:0] req_ctx;
  logic          wr_en, sc_ok;

  int n_run  = 0;
  int n_fail = 0;

  // reference reservation model
  logic          m_vld [NCTX];
  logic [AW-5:0] m_tag [NCTX];

  always #4 clk = ~clk;

  llsc_monitor #(.ADDR_W(AW), .NCTX(NCTX)) i_llsc_monitor (
    .clk, .rst_n, .req_valid, .req_addr, .req_ctx,
    .req_ll, .req_st, .req_cond, .wr_en, .sc_ok
  );

  task automatic chk(input string rq, input string what,
                     input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", rq, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NCTX; i++) begin
      m_vld[i] = 1'b0;
      m_tag[i] = '0;
    end
  endtask

  // model of the requirements: returns expected write and success
  task automatic model_step(input logic ll, input logic st, input logic cond,
                            input int ctx, input logic [AW-1:0] a,
                            output logic ew, output logic eo);
    logic [AW-5:0] t;
    t  = a[AW-1:4];
    ew = 1'b0;
    eo = 1'b0;
    if (st && !cond) ew = 1'b1;
    else if (st && cond) begin
      ew = m_vld[ctx] && (m_tag[ctx] == t);
      eo = ew;
    end else if (ll) begin
      m_vld[ctx] = 1'b1;
      m_tag[ctx] = t;
    end
    if (ew)
      for (int i = 0; i < NCTX; i++)
        if (m_vld[i] && m_tag[i] == t) m_vld[i] = 1'b0;
  endtask

  // drive at a falling edge, results read at the next falling edge
  task automatic issue(input string rq, input logic ll, input logic st,
                       input logic cond, input int ctx, input logic [AW-1:0] a,
                       input logic ew, input logic eo);
    logic mw, mo;
    req_valid = 1'b1;
    req_ll    = ll;
    req_st    = st;
    req_cond  = cond;
    req_ctx   = CW'(ctx);
    req_addr  = a;
    model_step(ll, st, cond, ctx, a, mw, mo);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rq, "wr_en", wr_en, ew);
    chk(rq, "sc_ok", sc_ok, eo);
  endtask

  task automatic do_reset();
    req_valid = 1'b0; req_ll = 1'b0; req_st = 1'b0; req_cond = 1'b0;
    req_ctx = '0; req_addr = '0;
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10", "wr_en after reset", wr_en, 1'b0);
    chk("R10", "sc_ok after reset", sc_ok, 1'b0);
    issue("R9", 1'b0, 1'b0, 1'b0, 0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_empty();
    issue("R6", 1'b0, 1'b1, 1'b1, 1, 32'h400, 1'b0, 1'b0);
    issue("R4", 1'b0, 1'b1, 1'b0, 2, 32'h400, 1'b1, 1'b0);
  endtask

  task automatic t_basic();
    issue("R2", 1'b1, 1'b0, 1'b0, 0, 32'h1000, 1'b0, 1'b0);
    issue("R7", 1'b0, 1'b1, 1'b1, 0, 32'h1000, 1'b1, 1'b1);
    // own reservation consumed by the success
    issue("R7", 1'b0, 1'b1, 1'b1, 0, 32'h1000, 1'b0, 1'b0);
  endtask

  task automatic t_wrong_ctx();
    issue("R2", 1'b1, 1'b0, 1'b0, 1, 32'h2000, 1'b0, 1'b0);
    issue("R7", 1'b0, 1'b1, 1'b1, 2, 32'h2000, 1'b0, 1'b0);
    // R8: failure left ctx1's reservation in place
    issue("R8", 1'b0, 1'b1, 1'b1, 1, 32'h2000, 1'b1, 1'b1);
  endtask

  task automatic t_lost_to_store();
    issue("R2", 1'b1, 1'b0, 1'b0, 0, 32'h3000, 1'b0, 1'b0);
    issue("R4", 1'b0, 1'b1, 1'b0, 3, 32'h3008, 1'b1, 1'b0);
    issue("R5", 1'b0, 1'b1, 1'b1, 0, 32'h3000, 1'b0, 1'b0);
  endtask

  task automatic t_same_block();
    issue("R1", 1'b1, 1'b0, 1'b0, 2, 32'h4003, 1'b0, 1'b0);
    issue("R1", 1'b0, 1'b1, 1'b1, 2, 32'h400C, 1'b1, 1'b1);
    // neighbouring block does not match
    issue("R1", 1'b1, 1'b0, 1'b0, 2, 32'h4010, 1'b0, 1'b0);
    issue("R1", 1'b0, 1'b1, 1'b1, 2, 32'h400F, 1'b0, 1'b0);
  endtask

  task automatic t_intervening_ll();
    issue("R2", 1'b1, 1'b0, 1'b0, 1, 32'h5000, 1'b0, 1'b0);
    issue("R2", 1'b1, 1'b0, 1'b0, 3, 32'h5004, 1'b0, 1'b0);
    issue("R7", 1'b0, 1'b1, 1'b1, 1, 32'h5000, 1'b1, 1'b1);
    // R5: ctx3's matching reservation was cleared too
    issue("R5", 1'b0, 1'b1, 1'b1, 3, 32'h5000, 1'b0, 1'b0);
  endtask

  task automatic t_replace();
    issue("R3", 1'b1, 1'b0, 1'b0, 0, 32'h6000, 1'b0, 1'b0);
    issue("R3", 1'b1, 1'b0, 1'b0, 0, 32'h7000, 1'b0, 1'b0);
    issue("R3", 1'b0, 1'b1, 1'b1, 0, 32'h6000, 1'b0, 1'b0);
    issue("R3", 1'b0, 1'b1, 1'b1, 0, 32'h7000, 1'b1, 1'b1);
  endtask

  task automatic t_flags();
    // ll+st acts as a plain store and reserves nothing
    issue("R11", 1'b1, 1'b1, 1'b0, 2, 32'h8000, 1'b1, 1'b0);
    issue("R11", 1'b0, 1'b1, 1'b1, 2, 32'h8000, 1'b0, 1'b0);
    // conditional without store: no write, no effect on reservations
    issue("R11", 1'b1, 1'b0, 1'b0, 1, 32'h9000, 1'b0, 1'b0);
    issue("R11", 1'b0, 1'b0, 1'b1, 1, 32'h9000, 1'b0, 1'b0);
    issue("R11", 1'b0, 1'b1, 1'b1, 1, 32'h9000, 1'b1, 1'b1);
  endtask

  task automatic t_reset_clears();
    issue("R10", 1'b1, 1'b0, 1'b0, 3, 32'hA000, 1'b0, 1'b0);
    do_reset();
    issue("R10", 1'b0, 1'b1, 1'b1, 3, 32'hA000, 1'b0, 1'b0);
  endtask

  task automatic t_random();
    logic [AW-1:0] pool [5];
    logic ew, eo, ll, st, cd;
    int ctx;
    logic [AW-1:0] a;
    pool[0] = 32'hB000; pool[1] = 32'hB004; pool[2] = 32'hB00F;
    pool[3] = 32'hB010; pool[4] = 32'hC000;
    do_reset();
    for (int k = 0; k < 400; k++) begin
      ll  = 1'($urandom_range(0, 1));
      st  = 1'($urandom_range(0, 1));
      cd  = 1'($urandom_range(0, 1));
      ctx = int'($urandom_range(0, NCTX - 1));
      a   = pool[$urandom_range(0, 4)];
      req_valid = 1'b1; req_ll = ll; req_st = st; req_cond = cd;
      req_ctx = CW'(ctx); req_addr = a;
      model_step(ll, st, cd, ctx, a, ew, eo);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9", "random wr_en", wr_en, ew);
      chk("R9", "random sc_ok", sc_ok, eo);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_empty();
    t_basic();
    t_wrong_ctx();
    t_lost_to_store();
    t_same_block();
    t_intervening_ll();
    t_replace();
    t_flags();
    t_reset_clears();
    t_random();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule